// File: doc/BRIEF.md
# Sigma-Delta Conversion Mode Sequencer

This block is the control core that sits between a converter's configuration register and an abstract modulator/filter pair. A 3-bit mode code and a channel index are loaded through a write strobe. The block then decides whether the modulator is powered, held in reset or running. It times the power-up wait and the filter settling period with two programmable cycle counters. When a period ends, it captures the filter output into the data register or into a per-channel calibration coefficient.

The block drives an active-low ready flag. The flag goes high when any operation is (re)started, goes low when a result or coefficient is stored, and goes high again when the data register is read. In continuous-read mode every new conversion result is offered to the serial output logic through a one-cycle presentation strobe. Otherwise a result is offered only when a read request arrives. Calibration modes write their coefficient and then move the block to idle without further action.

Top module: `adc_mode_seq`

## Requirements
- R1: While reset is asserted, and right after it, the mode is continuous conversion and the channel is 0. `rdy_n` is 1, `present` is 0, all data and coefficient registers are 0, and the modulator is powered and running (`mod_pwr`=1, `mod_run`=1, `filt_rst`=0).
- R2: The mode codes are 000 continuous, 001 single, 010 idle, 011 power-down, 100 internal zero-scale calibration, 101 internal full-scale calibration, 110 system zero-scale calibration and 111 system full-scale calibration. Idle gives `filt_rst`=1, `mod_run`=0 and `mod_pwr`=1. Power-down gives `mod_pwr`=0 and `filt_rst`=1.
- R3: In continuous mode the first result is stored `settle_cycles` clock edges after the mode write edge, and a further result follows every `settle_cycles` edges after that. Each stored result is the `filt_data` value and drives `rdy_n` low.
- R4: In single mode the result is stored `pwrup_cycles + settle_cycles` edges after the write edge. At that point `rdy_n` goes low and the block enters power-down (`mod_pwr`=0).
- R5: After a result is stored, `rdy_n` stays low until a `rd_req` pulse, which raises it one edge later, or until a new mode write.
- R6: A calibration write raises `rdy_n`, sets `cal_act`=1 and sets `cal_kind` to the two low mode bits. After `settle_cycles` edges `rdy_n` goes low and the block is idle (`cal_act`=0, `filt_rst`=1, `mod_run`=0).
- R7: A zero-scale calibration (mode bit 0 = 0) writes `filt_data` into the offset word of the selected channel. A full-scale calibration (mode bit 0 = 1) writes the full-scale word of that channel. The word for channel k sits at bits [k*DW +: DW] of `ofs_flat` or `fs_flat`, and no other word and not the data register changes.
- R8: A mode write during an operation aborts it. The settling count restarts from zero, no result from the aborted run is stored, and `rdy_n` is high until the next result.
- R9: With `cont_read`=1, `present` pulses for one cycle together with each new stored conversion result. With `cont_read`=0, `present` pulses only on the edge after a `rd_req`, and carries the current data register contents.
- R10: In idle and power-down, no result or coefficient is ever stored, whatever `filt_data` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode/channel write strobe |
| cfg_mode | input | 3 | Mode code |
| cfg_chan | input | CHW | Channel index |
| pwrup_cycles | input | CW | Power-up wait length in cycles (>=1) |
| settle_cycles | input | CW | Filter settling length in cycles (>=1) |
| cont_read | input | 1 | Present each result automatically |
| rd_req | input | 1 | Data register read request |
| filt_data | input | DW | Filter output word |
| mod_pwr | output | 1 | Modulator power enable |
| mod_run | output | 1 | Modulator/filter running |
| filt_rst | output | 1 | Modulator/filter held in reset |
| cal_act | output | 1 | Calibration in progress |
| cal_kind | output | 2 | Calibration type: bit1 system, bit0 full-scale |
| rdy_n | output | 1 | Active-low ready flag |
| data_reg | output | DW | Conversion data register |
| present | output | 1 | Data offered to serial output this cycle |
| ofs_flat | output | NCH*DW | Per-channel offset coefficients |
| fs_flat | output | NCH*DW | Per-channel full-scale coefficients |

## Verification
A wrong sequencer state shows up at the ports within one settling period. A stuck or miscounted counter moves the cycle in which `rdy_n` falls and `data_reg` changes, and the bench samples exactly one edge before and at the expected edge. A wrong mode decode shows at once in `mod_pwr`, `filt_rst` and `mod_run` on the cycle after the write. Misrouted calibration results appear in the wrong word of the coefficient buses, and the bench compares every word after every operation.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    MODE_CONT   = 3'b000,
    MODE_SINGLE = 3'b001,
    MODE_IDLE   = 3'b010,
    MODE_PDN    = 3'b011,
    MODE_ZS_INT = 3'b100,
    MODE_FS_INT = 3'b101,
    MODE_ZS_SYS = 3'b110,
    MODE_FS_SYS = 3'b111
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PDN,
    ST_PWRUP,
    ST_CONV,
    ST_CAL
  } state_e;
endpackage

// File: rtl/seq_cnt.sv
module seq_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          tc
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign tc = run && (cnt_q == limit - CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (tc)  cnt_d = '0;
    else if (run) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/seq_coef_bank.sv
module seq_coef_bank #(
  parameter int NCH = 4,
  parameter int DW  = 24,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              full,
  input  logic [CHW-1:0]    sel,
  input  logic [DW-1:0]     din,
  output logic [NCH*DW-1:0] ofs_flat,
  output logic [NCH*DW-1:0] fs_flat
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic ofs_en, fs_en;
    assign ofs_en = we && !full && (sel == CHW'(k));
    assign fs_en  = we &&  full && (sel == CHW'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ofs_flat[k*DW +: DW] <= '0;
      else if (ofs_en) ofs_flat[k*DW +: DW] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     fs_flat[k*DW +: DW] <= '0;
      else if (fs_en) fs_flat[k*DW +: DW] <= din;
    end
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int DW  = 24,
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [2:0]     cfg_mode,
  input  logic [CHW-1:0] cfg_chan,
  input  logic           rd_req,
  input  logic           cont_read,
  input  logic           tc,
  input  logic [DW-1:0]  filt_data,
  output state_e         state,
  output logic [1:0]     cal_kind,
  output logic [CHW-1:0] chan,
  output logic           rdy_n,
  output logic [DW-1:0]  data_reg,
  output logic           present,
  output logic           data_we,
  output logic           coef_we,
  output logic           coef_full
);
  mode_e          mode_q, mode_d;
  state_e         state_q, state_d;
  logic [CHW-1:0] chan_q, chan_d;
  logic           rdy_q, rdy_d;
  logic           pres_q, pres_d;

  function automatic state_e entry_state(mode_e m);
    case (m)
      MODE_CONT:   return ST_CONV;
      MODE_SINGLE: return ST_PWRUP;
      MODE_IDLE:   return ST_IDLE;
      MODE_PDN:    return ST_PDN;
      default:     return ST_CAL;
    endcase
  endfunction

  assign data_we   = !cfg_we && tc && (state_q == ST_CONV);
  assign coef_we   = !cfg_we && tc && (state_q == ST_CAL);
  assign coef_full = mode_q[0];

  always_comb begin
    mode_d  = mode_q;
    state_d = state_q;
    chan_d  = chan_q;
    rdy_d   = rdy_q;
    pres_d  = (data_we && cont_read) || (rd_req && !cont_read);
    if (cfg_we) begin
      mode_d  = mode_e'(cfg_mode);
      chan_d  = cfg_chan;
      state_d = entry_state(mode_e'(cfg_mode));
      rdy_d   = 1'b1;
    end else begin
      if (rd_req) rdy_d = 1'b1;
      if (tc) begin
        case (state_q)
          ST_PWRUP: state_d = ST_CONV;
          ST_CONV: begin
            rdy_d = 1'b0;
            if (mode_q != MODE_CONT) state_d = ST_PDN;
          end
          ST_CAL: begin
            rdy_d   = 1'b0;
            state_d = ST_IDLE;
            mode_d  = MODE_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_CONT;
      state_q <= ST_CONV;
      chan_q  <= '0;
      rdy_q   <= 1'b1;
      pres_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      state_q <= state_d;
      chan_q  <= chan_d;
      rdy_q   <= rdy_d;
      pres_q  <= pres_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_reg <= '0;
    else if (data_we) data_reg <= filt_data;
  end

  assign state    = state_q;
  assign cal_kind = mode_q[1:0];
  assign chan     = chan_q;
  assign rdy_n    = rdy_q;
  assign present  = pres_q;

  a_r8_write_raises_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> rdy_n);
  a_r5_rdy_falls_on_result: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(tc));
  a_r6_cal_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CAL && tc && !cfg_we) |=> (state_q == ST_IDLE && !rdy_n));
endmodule

// File: rtl/adc_mode_seq.sv
module adc_mode_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 24,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_mode,
  input  logic [CHW-1:0]    cfg_chan,
  input  logic [CW-1:0]     pwrup_cycles,
  input  logic [CW-1:0]     settle_cycles,
  input  logic              cont_read,
  input  logic              rd_req,
  input  logic [DW-1:0]     filt_data,
  output logic              mod_pwr,
  output logic              mod_run,
  output logic              filt_rst,
  output logic              cal_act,
  output logic [1:0]        cal_kind,
  output logic              rdy_n,
  output logic [DW-1:0]     data_reg,
  output logic              present,
  output logic [NCH*DW-1:0] ofs_flat,
  output logic [NCH*DW-1:0] fs_flat
);
  logic [1:0]     rst_sync;
  logic           rst_i;
  state_e         state;
  logic [CHW-1:0] chan;
  logic           tc, run;
  logic [CW-1:0]  limit;
  logic           data_we, coef_we, coef_full;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign run      = (state == ST_PWRUP) || (state == ST_CONV) || (state == ST_CAL);
  assign limit    = (state == ST_PWRUP) ? pwrup_cycles : settle_cycles;
  assign mod_pwr  = (state != ST_PDN);
  assign mod_run  = (state == ST_CONV) || (state == ST_CAL);
  assign filt_rst = (state == ST_IDLE) || (state == ST_PDN) || (state == ST_PWRUP);
  assign cal_act  = (state == ST_CAL);

  seq_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_i), .clr(cfg_we), .run(run), .limit(limit), .tc(tc)
  );

  seq_fsm #(.DW(DW), .CHW(CHW)) u_fsm (
    .clk(clk), .rst_n(rst_i), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_chan(cfg_chan), .rd_req(rd_req), .cont_read(cont_read), .tc(tc),
    .filt_data(filt_data), .state(state), .cal_kind(cal_kind), .chan(chan),
    .rdy_n(rdy_n), .data_reg(data_reg), .present(present), .data_we(data_we),
    .coef_we(coef_we), .coef_full(coef_full)
  );

  seq_coef_bank #(.NCH(NCH), .DW(DW)) u_coef (
    .clk(clk), .rst_n(rst_i), .we(coef_we), .full(coef_full), .sel(chan),
    .din(filt_data), .ofs_flat(ofs_flat), .fs_flat(fs_flat)
  );

  a_r10_no_store_in_reset: assert property (@(posedge clk) disable iff (!rst_i)
    filt_rst |-> (!data_we && !coef_we));
  a_r2_pdn_unpowered: assert property (@(posedge clk) disable iff (!rst_i)
    (cfg_we && cfg_mode == 3'b011) |=> !mod_pwr);
  a_r7_single_target: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0({data_we, coef_we}));
endmodule

// File: tb/sim_adc_mode_seq.sv
module sim_adc_mode_seq;
  localparam int NCH = 4;
  localparam int DW  = 24;
  localparam int CW  = 16;
  localparam int SETTLE = 5;
  localparam int PWRUP  = 3;

  typedef struct packed {
    logic [2:0]  mode;
    logic [1:0]  ch;
    logic [23:0] val;
    logic [4:0]  wt;
    logic [1:0]  tgt;   // 0 data, 1 offset, 2 full-scale
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{3'd0, 2'd0, 24'h1A2B3C, 5'd5, 2'd0},
    '{3'd1, 2'd1, 24'h00FF10, 5'd8, 2'd0},
    '{3'd4, 2'd2, 24'h7F0001, 5'd5, 2'd1},
    '{3'd5, 2'd3, 24'h400000, 5'd5, 2'd2},
    '{3'd6, 2'd1, 24'h800123, 5'd5, 2'd1},
    '{3'd7, 2'd0, 24'h3C3C3C, 5'd5, 2'd2}
  };

  logic clk = 1'b0;
  logic rst_n, cfg_we, cont_read, rd_req;
  logic [2:0] cfg_mode;
  logic [1:0] cfg_chan;
  logic [CW-1:0] pwrup_cycles, settle_cycles;
  logic [DW-1:0] filt_data;
  logic mod_pwr, mod_run, filt_rst, cal_act, rdy_n, present;
  logic [1:0] cal_kind;
  logic [DW-1:0] data_reg;
  logic [NCH*DW-1:0] ofs_flat, fs_flat;

  int nchk = 0, nfail = 0;
  logic done = 1'b0;
  logic [DW-1:0] exp_data;
  logic [DW-1:0] exp_ofs [NCH];
  logic [DW-1:0] exp_fs  [NCH];

  always #5 clk = ~clk;

  adc_mode_seq #(.NCH(NCH), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_chan(cfg_chan), .pwrup_cycles(pwrup_cycles), .settle_cycles(settle_cycles),
    .cont_read(cont_read), .rd_req(rd_req), .filt_data(filt_data),
    .mod_pwr(mod_pwr), .mod_run(mod_run), .filt_rst(filt_rst), .cal_act(cal_act),
    .cal_kind(cal_kind), .rdy_n(rdy_n), .data_reg(data_reg), .present(present),
    .ofs_flat(ofs_flat), .fs_flat(fs_flat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] m, input logic [1:0] c, input logic [DW-1:0] v);
    @(negedge clk);
    cfg_mode = m; cfg_chan = c; filt_data = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic read_pulse();
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic chk_coefs(input string req);
    for (int k = 0; k < NCH; k++) begin
      chk(req, 32'(ofs_flat[k*DW +: DW]), 32'(exp_ofs[k]));
      chk(req, 32'(fs_flat[k*DW +: DW]), 32'(exp_fs[k]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cont_read = 1'b0; rd_req = 1'b0;
    cfg_mode = 3'd0; cfg_chan = 2'd0; filt_data = '0;
    pwrup_cycles = CW'(PWRUP); settle_cycles = CW'(SETTLE);
    exp_data = '0;
    for (int k = 0; k < NCH; k++) begin exp_ofs[k] = '0; exp_fs[k] = '0; end

    // R1 reset state
    waitn(3);
    chk("R1 rdy_n", 32'(rdy_n), 1);
    chk("R1 present", 32'(present), 0);
    chk("R1 data", 32'(data_reg), 0);
    chk("R1 mod_pwr", 32'(mod_pwr), 1);
    chk("R1 mod_run", 32'(mod_run), 1);
    chk("R1 filt_rst", 32'(filt_rst), 0);
    chk_coefs("R1 coef");
    rst_n = 1'b1;
    waitn(4);

    // vector table: one operation per row
    for (int i = 0; i < 6; i++) begin
      string rq;
      rq = (VEC[i].mode == 3'd0) ? "R3" : (VEC[i].mode == 3'd1) ? "R4" : "R6";
      wr(VEC[i].mode, VEC[i].ch, VEC[i].val);
      if (VEC[i].mode[2]) begin
        chk("R6 cal_act", 32'(cal_act), 1);
        chk("R6 cal_kind", 32'(cal_kind), 32'(VEC[i].mode[1:0]));
      end
      waitn(int'(VEC[i].wt) - 1);
      chk({rq, " rdy_n before"}, 32'(rdy_n), 1);
      chk({rq, " data before"}, 32'(data_reg), 32'(exp_data));
      waitn(1);
      chk({rq, " rdy_n done"}, 32'(rdy_n), 0);
      case (VEC[i].tgt)
        2'd0: exp_data = VEC[i].val;
        2'd1: exp_ofs[VEC[i].ch] = VEC[i].val;
        default: exp_fs[VEC[i].ch] = VEC[i].val;
      endcase
      chk({rq, " data"}, 32'(data_reg), 32'(exp_data));
      chk_coefs("R7 coef words");
      if (VEC[i].mode == 3'd1) chk("R4 powered down", 32'(mod_pwr), 0);
      if (VEC[i].mode[2]) begin
        chk("R6 idle filt_rst", 32'(filt_rst), 1);
        chk("R6 idle mod_run", 32'(mod_run), 0);
        chk("R6 cal_act off", 32'(cal_act), 0);
      end
    end

    // R3 + R9: repeating results with automatic presentation
    cont_read = 1'b1;
    wr(3'd0, 2'd0, 24'hABCDEF);
    waitn(SETTLE);
    chk("R3 first", 32'(data_reg), 32'hABCDEF);
    chk("R9 present auto", 32'(present), 1);
    waitn(1);
    chk("R9 present one cycle", 32'(present), 0);
    filt_data = 24'h123456;
    waitn(SETTLE - 1);
    chk("R3 second", 32'(data_reg), 32'h123456);
    chk("R3 rdy_n", 32'(rdy_n), 0);
    chk("R9 present second", 32'(present), 1);
    cont_read = 1'b0;

    // R9: presentation only on request
    wr(3'd0, 2'd0, 24'h0F0F0F);
    waitn(SETTLE);
    chk("R9 no auto present", 32'(present), 0);
    chk("R3 data", 32'(data_reg), 32'h0F0F0F);
    read_pulse();
    chk("R9 present on read", 32'(present), 1);
    chk("R5 rdy_n after read", 32'(rdy_n), 1);
    exp_data = 24'h0F0F0F;

    // R8: abort mid-settle
    wr(3'd0, 2'd0, 24'h555555);
    waitn(3);
    wr(3'd0, 2'd0, 24'h666666);
    waitn(SETTLE - 1);
    chk("R8 rdy_n held", 32'(rdy_n), 1);
    chk("R8 no early data", 32'(data_reg), 32'(exp_data));
    waitn(1);
    chk("R8 restarted result", 32'(data_reg), 32'h666666);
    chk("R8 rdy_n low", 32'(rdy_n), 0);

    // R5: ready held low after single conversion until read
    wr(3'd1, 2'd2, 24'h24680A);
    waitn(PWRUP + SETTLE);
    exp_data = 24'h24680A;
    chk("R4 data", 32'(data_reg), 32'(exp_data));
    waitn(10);
    chk("R5 rdy_n held low", 32'(rdy_n), 0);
    chk("R4 still down", 32'(mod_pwr), 0);
    read_pulse();
    chk("R5 rdy_n after read", 32'(rdy_n), 1);

    // R2 + R10: idle
    wr(3'd2, 2'd0, 24'hDEAD01);
    chk("R2 idle filt_rst", 32'(filt_rst), 1);
    chk("R2 idle mod_run", 32'(mod_run), 0);
    chk("R2 idle mod_pwr", 32'(mod_pwr), 1);
    waitn(20);
    chk("R10 idle data", 32'(data_reg), 32'(exp_data));
    chk("R10 idle rdy_n", 32'(rdy_n), 1);
    chk_coefs("R10 idle coef");

    // R2 + R10: power-down
    wr(3'd3, 2'd1, 24'hDEAD02);
    chk("R2 pdn mod_pwr", 32'(mod_pwr), 0);
    chk("R2 pdn filt_rst", 32'(filt_rst), 1);
    waitn(20);
    chk("R10 pdn data", 32'(data_reg), 32'(exp_data));
    chk_coefs("R10 pdn coef");

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule